// File: doc/BRIEF.md
# CRC-8 Identifier Validator

This block checks a 64-bit identifier delivered one byte per transfer. The first seven bytes, a model code followed by six unique bytes, are pushed through an eight-stage serial shift register that implements the generator polynomial x^8 + x^5 + x^4 + 1. Bytes are consumed one bit per clock. When the seventh byte has been fully shifted, the resulting check value is frozen on `crc_o` and `crc_done_o` rises. The eighth byte is then offered and compared with the frozen value. The outcome appears on `verdict_o` and `match_o`.

The same datapath generates check bytes. A caller that feeds only the seven payload bytes reads the check byte from `crc_o` once `crc_done_o` is high, and never needs to send an eighth byte. Typical model codes are 72h, 74h and 78h. The block places no restriction on the model byte.

Top module: `id_crc_check`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `ready_o`=1, `crc_done_o`=0, `verdict_o`=0, `match_o`=0 and `crc_o`=00h.
- R2: A byte is taken at a rising edge where `byte_vld_i` and `ready_o` are both high and `start_i` is low. Its bits enter the register least-significant first, one per clock. `ready_o` reads 0 for the 8 cycles that follow the accepting edge and returns to 1 after the 8th bit.
- R3: The register starts at 00h. For each bit b, let f = b XOR stage0. The register shifts toward stage 0, f enters stage 7, and f is XORed into stages 3 and 2 (the reflected constant 8Ch). Over the bytes 02 1C B8 01 00 00 00 the result on `crc_o` is A2h.
- R4: `crc_done_o` rises in the same cycle that `ready_o` returns after the seventh payload byte, and not earlier. While `crc_done_o` is high and `start_i` is low, `crc_o` holds its value.
- R5: With `crc_done_o` high, one further accepted byte is the check byte. From the next cycle `verdict_o`=1, and `match_o` is 1 exactly when that byte equals `crc_o`.
- R6: `byte_vld_i` has no effect while `ready_o` is low. The byte it carries does not change the result.
- R7: Once `verdict_o` is high, `ready_o` is 0. Further bytes are ignored, and `crc_o`, `match_o` and `verdict_o` hold until `start_i`.
- R8: A `start_i` pulse clears the register to 00h, drops `crc_done_o`, `verdict_o` and `match_o`, restarts the byte count and aborts any byte in flight. It wins over a `byte_vld_i` in the same cycle, which is not taken.
- R9: Flipping any single bit of any of the eight identifier bytes makes `match_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear and begin a new identifier |
| byte_i | input | 8 | Identifier byte |
| byte_vld_i | input | 1 | Byte strobe |
| ready_o | output | 1 | A byte can be taken this cycle |
| crc_done_o | output | 1 | Seven payload bytes processed, `crc_o` final |
| verdict_o | output | 1 | Check byte compared |
| match_o | output | 1 | Check byte equalled the computed CRC |
| crc_o | output | 8 | Shift register contents / computed check byte |

## Verification
The assertions assume two things about the caller: the feeder is loaded only when its bit counter is empty, and `start_i` is the only event that can disturb a frozen result. The bench keeps to both by offering a byte only after it has sampled `ready_o` high. It also raises `byte_vld_i` deliberately while the block is busy or has already given its verdict, so that each ignore rule is exercised and the effect can be seen on the ports. Expected check values come from a bit-serial model in the bench. Model codes 72h, 74h and 78h are swept with generated unique bytes, and every single-bit corruption of one identifier is tried.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_PAYLOAD_BYTES = 7;
  localparam logic [7:0] DEF_POLY_REFL = 8'h8C;

  typedef enum logic [1:0] {
    PH_COLLECT   = 2'd0,
    PH_AWAIT_CHK = 2'd1,
    PH_VERDICT   = 2'd2
  } phase_e;
endpackage

// File: rtl/idcrc_bit_feeder.sv
module idcrc_bit_feeder #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] byte_in,
  output logic         busy,
  output logic         bit_o,
  output logic         last_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load) begin
      sreg <= byte_in;
      cnt  <= CW'(W);
    end else if (cnt != '0) begin
      sreg <= {1'b0, sreg[W-1:1]};
      cnt  <= cnt - CW'(1);
    end
  end

  assign busy   = (cnt != '0);
  assign bit_o  = sreg[0];
  assign last_o = (cnt == CW'(1));

  // R2
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr && !load) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/idcrc_lfsr.sv
module idcrc_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h8C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         bit_in,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] state;
  logic [W-1:0] nxt;
  logic         fb;

  assign fb = bit_in ^ state[0];

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W - 1) begin : g_top
      assign nxt[i] = fb & POLY[i];
    end else begin : g_mid
      assign nxt[i] = state[i+1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) state <= '0;
    else if (step)  state <= nxt;
  end

  assign crc_o = state;

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_o == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(crc_o));
endmodule

// File: rtl/id_crc_check.sv
module id_crc_check
  import idcrc_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned PAYLOAD_BYTES = DEF_PAYLOAD_BYTES,
  parameter logic [BYTE_W-1:0] POLY_REFL = DEF_POLY_REFL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic              ready_o,
  output logic              crc_done_o,
  output logic              verdict_o,
  output logic              match_o,
  output logic [BYTE_W-1:0] crc_o
);
  localparam int unsigned CNT_W = $clog2(PAYLOAD_BYTES + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  byte_cnt;
  logic              match_q;
  logic              busy;
  logic              bit_w;
  logic              last_w;
  logic              load;
  logic              chk_take;
  logic [BYTE_W-1:0] crc_w;

  assign ready_o  = ((phase == PH_COLLECT) && !busy) || (phase == PH_AWAIT_CHK);
  assign load     = byte_vld_i && !start_i && (phase == PH_COLLECT) && !busy;
  assign chk_take = byte_vld_i && !start_i && (phase == PH_AWAIT_CHK);

  idcrc_bit_feeder #(.W(BYTE_W)) feeder_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_i),
    .load   (load),
    .byte_in(byte_i),
    .busy   (busy),
    .bit_o  (bit_w),
    .last_o (last_w)
  );

  idcrc_lfsr #(.W(BYTE_W), .POLY(POLY_REFL)) lfsr_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_i),
    .step  (busy),
    .bit_in(bit_w),
    .crc_o (crc_w)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      phase    <= PH_COLLECT;
      byte_cnt <= '0;
      match_q  <= 1'b0;
    end else begin
      case (phase)
        PH_COLLECT: begin
          if (load) byte_cnt <= byte_cnt + CNT_W'(1);
          if (last_w && (byte_cnt == CNT_W'(PAYLOAD_BYTES))) phase <= PH_AWAIT_CHK;
        end
        PH_AWAIT_CHK: begin
          if (chk_take) begin
            match_q <= (byte_i == crc_w);
            phase   <= PH_VERDICT;
          end
        end
        default: ;
      endcase
    end
  end

  assign crc_o      = crc_w;
  assign crc_done_o = (phase != PH_COLLECT);
  assign verdict_o  = (phase == PH_VERDICT);
  assign match_o    = match_q;

  // R4
  frozen_crc_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_done_o && !start_i) |=> $stable(crc_o));

  // R5
  verdict_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(verdict_o) |-> ($past(crc_done_o) && $past(byte_vld_i)));

  // R5
  compare_chk: assert property (@(posedge clk) disable iff (rst)
    chk_take |=> (verdict_o && (match_o == ($past(byte_i) == $past(crc_o)))));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && !start_i) |=> $stable(byte_cnt));

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_o && !start_i) |=> (verdict_o && !ready_o && $stable(match_o)));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!crc_done_o && !verdict_o && !match_o && ready_o));
endmodule

// File: tb/id_crc_check_tb.sv
module id_crc_check_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_i = 1'b0;
  logic       ready_o, crc_done_o, verdict_o, match_o;
  logic [7:0] crc_o;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  logic [7:0] fr [8];
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  id_crc_check dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_i(byte_i),
    .byte_vld_i(byte_vld_i), .ready_o(ready_o), .crc_done_o(crc_done_o),
    .verdict_o(verdict_o), .match_o(match_o), .crc_o(crc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic f;
        f = fr[k][b] ^ c[0];
        c = c >> 1;
        if (f) c = c ^ 8'h8C;
      end
    end
    return c;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(crc_o == 8'h00, "R8 crc cleared", crc_o, 8'h00);
    chk(!crc_done_o && !verdict_o && !match_o, "R8 flags cleared",
        {5'd0, crc_done_o, verdict_o, match_o}, 8'h00);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit junk, input bit last);
    while (!ready_o) @(negedge clk);
    byte_i = b;
    byte_vld_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    byte_vld_i = junk;
    byte_i = ~b;
    chk(!ready_o, "R2 ready low after accept", {7'd0, ready_o}, 8'h00);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      if (i == 3) byte_vld_i = 1'b0;
      if (ready_o || crc_done_o) begin
        chk(1'b0, "R2/R4 busy window", {6'd0, ready_o, crc_done_o}, 8'h00);
      end
    end
    byte_vld_i = 1'b0;
    @(negedge clk);
    chk(ready_o, "R2 ready back after 8 bits", {7'd0, ready_o}, 8'h01);
    chk(crc_done_o == last, "R4 done timing", {7'd0, crc_done_o}, {7'd0, last});
  endtask

  task automatic run_frame(input bit junk, input bit exp_match);
    logic [7:0] exp_crc;
    logic [7:0] held;
    pulse_start();
    for (int k = 0; k < 7; k++) send_byte(fr[k], junk, k == 6);
    exp_crc = ref_crc(7);
    chk(crc_o == exp_crc, "R3 crc value", crc_o, exp_crc);
    repeat (3) @(negedge clk);
    chk(crc_o == exp_crc && crc_done_o, "R4 crc held", crc_o, exp_crc);
    byte_i = fr[7];
    byte_vld_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    byte_vld_i = 1'b0;
    chk(verdict_o, "R5 verdict", {7'd0, verdict_o}, 8'h01);
    chk(match_o == exp_match, exp_match ? "R5 match" : "R9 mismatch",
        {7'd0, match_o}, {7'd0, exp_match});
    held = crc_o;
    byte_i = exp_crc;
    byte_vld_i = 1'b1;
    repeat (2) @(negedge clk);
    byte_vld_i = 1'b0;
    chk(!ready_o && verdict_o && match_o == exp_match && crc_o == held,
        "R7 verdict held", {5'd0, ready_o, verdict_o, match_o}, {6'd1, exp_match, 1'b0} >> 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] models [3];
    logic [7:0] base [8];
    logic [7:0] good;
    models[0] = 8'h72; models[1] = 8'h74; models[2] = 8'h78;

    repeat (3) @(negedge clk);
    chk(ready_o && !crc_done_o && !verdict_o && !match_o && crc_o == 8'h00,
        "R1 in reset", crc_o, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_o && !crc_done_o && !verdict_o && !match_o && crc_o == 8'h00,
        "R1 after reset", {4'd0, ready_o, crc_done_o, verdict_o, match_o}, 8'h08);

    // R3 known vector
    fr[0] = 8'h02; fr[1] = 8'h1C; fr[2] = 8'hB8; fr[3] = 8'h01;
    fr[4] = 8'h00; fr[5] = 8'h00; fr[6] = 8'h00; fr[7] = 8'hA2;
    run_frame(1'b0, 1'b1);
    chk(crc_o == 8'hA2, "R3 known vector", crc_o, 8'hA2);

    // R3/R5/R6 sweep over model codes
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 6; p++) begin
        fr[0] = models[m];
        for (int k = 1; k < 7; k++) begin
          seed = seed * 32'd1103515245 + 32'd12345;
          fr[k] = seed[23:16];
        end
        fr[7] = ref_crc(7);
        run_frame(p[0], 1'b1);
      end
    end

    // R9 every single-bit corruption
    for (int k = 0; k < 8; k++) base[k] = fr[k];
    good = base[7];
    for (int pos = 0; pos < 64; pos++) begin
      for (int k = 0; k < 8; k++) fr[k] = base[k];
      fr[pos / 8][pos % 8] = ~fr[pos / 8][pos % 8];
      run_frame(1'b0, 1'b0);
    end
    chk(good == base[7], "R9 base intact", good, base[7]);

    // R8 start beats a simultaneous byte
    for (int k = 0; k < 8; k++) fr[k] = base[k];
    pulse_start();
    send_byte(8'h5A, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b1;
    byte_vld_i = 1'b1;
    byte_i = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    byte_vld_i = 1'b0;
    chk(crc_o == 8'h00 && ready_o, "R8 start priority", crc_o, 8'h00);

    // R8 start aborts a byte in flight
    byte_i = 8'hC3;
    byte_vld_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    byte_vld_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(ready_o && crc_o == 8'h00, "R8 abort in flight", crc_o, 8'h00);
    @(negedge clk);
    chk(crc_o == 8'h00, "R8 no residual bits", crc_o, 8'h00);
    run_frame(1'b1, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule